// File: doc/BRIEF.md
# Reorder Buffer with Precise Fault Retirement

This block keeps the speculative results of an out-of-order core in a ring of entries and hands them to the architectural register file strictly in program order. An instruction claims the entry at the tail when it is dispatched and receives that entry's index as its tag. Execution units later report a result, or a fault, against the tag in any order. The oldest entry leaves the ring only once it has been reported complete. A clean result is written into the register file that lives inside the block. A faulting entry writes nothing. Instead it empties the whole ring in one cycle and presents its own PC together with the handler address, so that fetch can be redirected.

A lookup port serves the operand stage. It returns the value of the youngest in-flight entry that writes the requested register, and says whether that value has been produced yet. When no live entry names the register, it returns the contents of the architectural register file.

Top module: `rob_core`

## Requirements
- R1: After reset the ring is empty: `alloc_stall`=0, `alloc_tag`=0, `commit_valid`=0, `fault_redirect`=0, and architectural register i reads `ARF_RESET_BASE`+i through the lookup port with `lookup_ready`=1.
- R2: Each accepted allocation returns the current tail index on `alloc_tag`, and the next tag is one greater, wrapping modulo `DEPTH`.
- R3: When `DEPTH` entries are live, `alloc_stall`=1 and an allocation is ignored. This holds even in a cycle in which the head retires.
- R4: When several live entries write the same register, the lookup port reports the youngest of them.
- R5: When no live entry writes the register, the lookup port returns the architectural value with `lookup_ready`=1.
- R6: When the youngest matching entry has not been written back, `lookup_ready`=0.
- R7: Writebacks may arrive in any order, but entries retire one per cycle in allocation order. `commit_valid` stays 0 while the head entry is not done.
- R8: A retiring entry without a fault writes its value to its destination register. After the entry has left the ring, lookups of that register return the value.
- R9: A done head entry with its fault flag set raises `fault_redirect` for one cycle, with `fault_pc` equal to the entry's PC and `handler_pc` equal to `HANDLER_PC`. No register is written. In the next cycle the ring is empty (`alloc_tag`=0) and every earlier entry is gone from the lookup.
- R10: During the fault cycle, `alloc_stall`=1, and any allocation or writeback presented in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a new entry |
| alloc_pc | input | PCW | PC of the dispatched instruction |
| alloc_dst | input | log2(NREG) | Destination register |
| alloc_stall | output | 1 | Allocation refused this cycle |
| alloc_tag | output | log2(DEPTH) | Index the next allocation receives |
| lookup_reg | input | log2(NREG) | Register to look up |
| lookup_value | output | XLEN | Newest value for that register |
| lookup_ready | output | 1 | Value is valid |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | log2(DEPTH) | Entry being written back |
| wb_value | input | XLEN | Result value |
| wb_fault | input | 1 | Instruction faulted |
| commit_valid | output | 1 | Head retires cleanly this cycle |
| commit_reg | output | log2(NREG) | Register written by the retiring entry |
| commit_value | output | XLEN | Value written by the retiring entry |
| fault_redirect | output | 1 | Head faults; ring flushes at this edge |
| fault_pc | output | PCW | PC of the faulting entry |
| handler_pc | output | PCW | Address of the fault handler |

## Verification
Two situations are hard to reach from the ports. The first is a retirement in the same cycle as an allocation attempt while the ring is full. The bench fills all entries with no results reported and then writes back only the head. In the following cycle, while `commit_valid` is high, it presents another allocation and checks that the tail has not moved. The second is a fault cycle that also carries an allocation and a writeback. The bench lets a younger entry complete first, faults the older head, and drives both strobes during the redirect cycle. Lookups afterwards confirm that no state from those entries survives.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_RETIRE = 2'd1,
        CM_FLUSH  = 2'd2
    } commit_act_e;
endpackage

// File: rtl/rob_arf.sv
module rob_arf #(
    parameter int          NREG       = 16,
    parameter int          XLEN       = 32,
    parameter logic [XLEN-1:0] RESET_BASE = '0,
    localparam int         RW         = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   raddr,
    output logic [XLEN-1:0] rdata,
    input  logic            we,
    input  logic [RW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata
);
    logic [NREG-1:0][XLEN-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= RESET_BASE + XLEN'(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[raddr];

    // A retire write must be visible in the following cycle (R8)
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
    parameter int DEPTH = 8,
    parameter int NREG  = 16,
    parameter int XLEN  = 32,
    localparam int IDXW = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG)
) (
    input  logic [DEPTH-1:0]           ent_valid,
    input  logic [DEPTH-1:0]           ent_done,
    input  logic [DEPTH-1:0][RW-1:0]   ent_dst,
    input  logic [DEPTH-1:0][XLEN-1:0] ent_value,
    input  logic [IDXW-1:0]            tail_idx,
    input  logic [RW-1:0]              reg_id,
    input  logic [XLEN-1:0]            arf_value,
    output logic [XLEN-1:0]            value,
    output logic                       ready
);
    logic            hit;
    logic [IDXW-1:0] sel;

    // Walk from the slot just below the tail back around the ring; first match is youngest.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDXW-1:0] pos;
            pos = tail_idx - IDXW'(k) - IDXW'(1);
            if (!hit && ent_valid[pos] && ent_dst[pos] == reg_id) begin
                hit = 1'b1;
                sel = pos;
            end
        end
    end

    always_comb begin
        if (hit) begin
            ready = ent_done[sel];
            value = ent_done[sel] ? ent_value[sel] : '0;
        end else begin
            ready = 1'b1;
            value = arf_value;
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int              DEPTH          = 8,
    parameter int              NREG           = 16,
    parameter int              XLEN           = 32,
    parameter int              PCW            = 32,
    parameter logic [PCW-1:0]  HANDLER_PC     = 32'h0000_8000,
    parameter logic [XLEN-1:0] ARF_RESET_BASE = 32'h0000_0100,
    localparam int             IDXW           = $clog2(DEPTH),
    localparam int             RW             = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [PCW-1:0]  alloc_pc,
    input  logic [RW-1:0]   alloc_dst,
    output logic            alloc_stall,
    output logic [IDXW-1:0] alloc_tag,
    input  logic [RW-1:0]   lookup_reg,
    output logic [XLEN-1:0] lookup_value,
    output logic            lookup_ready,
    input  logic            wb_valid,
    input  logic [IDXW-1:0] wb_tag,
    input  logic [XLEN-1:0] wb_value,
    input  logic            wb_fault,
    output logic            commit_valid,
    output logic [RW-1:0]   commit_reg,
    output logic [XLEN-1:0] commit_value,
    output logic            fault_redirect,
    output logic [PCW-1:0]  fault_pc,
    output logic [PCW-1:0]  handler_pc
);
    import rob_pkg::*;

    typedef struct packed {
        logic            valid;
        logic            done;
        logic            fault;
        logic [PCW-1:0]  pc;
        logic [RW-1:0]   dst;
        logic [XLEN-1:0] value;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [IDXW:0]      head;
        logic [IDXW:0]      tail;
    } state_t;

    state_t          st_d, st_q;
    commit_act_e     act;
    entry_t          hd;
    logic [IDXW-1:0] head_idx, tail_idx;
    logic            full;
    logic            arf_we;
    logic [XLEN-1:0] arf_rdata;

    assign head_idx = st_q.head[IDXW-1:0];
    assign tail_idx = st_q.tail[IDXW-1:0];
    assign hd       = st_q.ent[head_idx];
    assign full     = (st_q.head[IDXW] != st_q.tail[IDXW]) && (head_idx == tail_idx);

    always_comb begin
        if (hd.valid && hd.done) act = hd.fault ? CM_FLUSH : CM_RETIRE;
        else                     act = CM_IDLE;
    end

    assign alloc_stall    = full || (act == CM_FLUSH);
    assign alloc_tag      = tail_idx;
    assign commit_valid   = (act == CM_RETIRE);
    assign commit_reg     = hd.dst;
    assign commit_value   = hd.value;
    assign fault_redirect = (act == CM_FLUSH);
    assign fault_pc       = hd.pc;
    assign handler_pc     = HANDLER_PC;
    assign arf_we         = commit_valid;

    always_comb begin
        st_d = st_q;
        if (act == CM_FLUSH) begin
            for (int i = 0; i < DEPTH; i++) st_d.ent[i].valid = 1'b0;
            st_d.head = '0;
            st_d.tail = '0;
        end else begin
            if (wb_valid && st_q.ent[wb_tag].valid) begin
                st_d.ent[wb_tag].done  = 1'b1;
                st_d.ent[wb_tag].fault = wb_fault;
                st_d.ent[wb_tag].value = wb_value;
            end
            if (alloc_valid && !alloc_stall) begin
                st_d.ent[tail_idx].valid = 1'b1;
                st_d.ent[tail_idx].done  = 1'b0;
                st_d.ent[tail_idx].fault = 1'b0;
                st_d.ent[tail_idx].pc    = alloc_pc;
                st_d.ent[tail_idx].dst   = alloc_dst;
                st_d.ent[tail_idx].value = '0;
                st_d.tail = st_q.tail + 1'b1;
            end
            if (act == CM_RETIRE) begin
                st_d.ent[head_idx].valid = 1'b0;
                st_d.head = st_q.head + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [DEPTH-1:0]           v_valid, v_done;
    logic [DEPTH-1:0][RW-1:0]   v_dst;
    logic [DEPTH-1:0][XLEN-1:0] v_value;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign v_valid[g] = st_q.ent[g].valid;
        assign v_done[g]  = st_q.ent[g].done;
        assign v_dst[g]   = st_q.ent[g].dst;
        assign v_value[g] = st_q.ent[g].value;
    end

    rob_arf #(.NREG(NREG), .XLEN(XLEN), .RESET_BASE(ARF_RESET_BASE)) u_arf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (lookup_reg),
        .rdata (arf_rdata),
        .we    (arf_we),
        .waddr (hd.dst),
        .wdata (hd.value)
    );

    rob_lookup #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) u_lookup (
        .ent_valid (v_valid),
        .ent_done  (v_done),
        .ent_dst   (v_dst),
        .ent_value (v_value),
        .tail_idx  (tail_idx),
        .reg_id    (lookup_reg),
        .arf_value (arf_rdata),
        .value     (lookup_value),
        .ready     (lookup_ready)
    );

    // Accepted allocation moves the tag on by one, modulo depth (R2)
    p_tag_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_stall) |=> alloc_tag == $past(alloc_tag) + IDXW'(1));

    // A refused allocation outside a flush leaves the tail where it was (R3)
    p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_stall && !fault_redirect) |=> $stable(alloc_tag));

    // A fault empties the ring by the next cycle (R9)
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_redirect |=> (alloc_tag == '0 && !alloc_stall && !commit_valid && !fault_redirect));
endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
    localparam int DEPTH = 8;
    localparam int NREG  = 16;
    localparam int XLEN  = 32;
    localparam int PCW   = 32;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int RW    = $clog2(NREG);
    localparam logic [PCW-1:0]  HPC  = 32'h0000_8000;
    localparam logic [XLEN-1:0] BASE = 32'h0000_0100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_valid = 1'b0;
    logic [PCW-1:0]  alloc_pc = '0;
    logic [RW-1:0]   alloc_dst = '0;
    logic            alloc_stall;
    logic [IDXW-1:0] alloc_tag;
    logic [RW-1:0]   lookup_reg = '0;
    logic [XLEN-1:0] lookup_value;
    logic            lookup_ready;
    logic            wb_valid = 1'b0;
    logic [IDXW-1:0] wb_tag = '0;
    logic [XLEN-1:0] wb_value = '0;
    logic            wb_fault = 1'b0;
    logic            commit_valid;
    logic [RW-1:0]   commit_reg;
    logic [XLEN-1:0] commit_value;
    logic            fault_redirect;
    logic [PCW-1:0]  fault_pc;
    logic [PCW-1:0]  handler_pc;

    always #10 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .PCW(PCW),
               .HANDLER_PC(HPC), .ARF_RESET_BASE(BASE)) u_rob_core (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_dst(alloc_dst),
        .alloc_stall(alloc_stall), .alloc_tag(alloc_tag),
        .lookup_reg(lookup_reg), .lookup_value(lookup_value), .lookup_ready(lookup_ready),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
        .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_value(commit_value),
        .fault_redirect(fault_redirect), .fault_pc(fault_pc), .handler_pc(handler_pc)
    );

    int checks = 0;
    int errors = 0;

    logic [RW-1:0]   exp_dst   [DEPTH];
    logic [PCW-1:0]  exp_pc    [DEPTH];
    logic [XLEN-1:0] exp_val   [DEPTH];
    logic            exp_fault [DEPTH];
    logic [IDXW-1:0] sb_q[$];

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: the main thread always sits just after a falling edge.
    task automatic do_alloc(input logic [RW-1:0] dst, input logic [PCW-1:0] pc);
        check(!alloc_stall, "R3 unexpected stall", 64'(alloc_stall), 64'd0);
        exp_dst[alloc_tag]   = dst;
        exp_pc[alloc_tag]    = pc;
        exp_fault[alloc_tag] = 1'b0;
        sb_q.push_back(alloc_tag);
        alloc_valid = 1'b1; alloc_dst = dst; alloc_pc = pc;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_wb(input logic [IDXW-1:0] tag, input logic [XLEN-1:0] val, input logic flt);
        exp_val[tag] = val;
        exp_fault[tag] = flt;
        wb_valid = 1'b1; wb_tag = tag; wb_value = val; wb_fault = flt;
        @(negedge clk);
        wb_valid = 1'b0; wb_fault = 1'b0;
    endtask

    task automatic look(input logic [RW-1:0] r, input logic [XLEN-1:0] v, input logic rdy, input string req);
        lookup_reg = r;
        #1;
        check(lookup_ready == rdy, req, 64'(lookup_ready), 64'(rdy));
        if (rdy) check(lookup_value == v, req, 64'(lookup_value), 64'(v));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compares each retirement or fault against the scoreboard queue.
    initial begin
        forever begin
            @(negedge clk);
            #8;
            if (rst_n && (commit_valid || fault_redirect)) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 retirement with empty scoreboard", 64'(commit_reg), 64'd0);
                end else begin
                    logic [IDXW-1:0] t;
                    t = sb_q.pop_front();
                    if (commit_valid) begin
                        check(!exp_fault[t], "R9 clean retire of faulting entry", 64'd1, 64'd0);
                        check(commit_reg == exp_dst[t], "R7 retire order dst", 64'(commit_reg), 64'(exp_dst[t]));
                        check(commit_value == exp_val[t], "R8 retire value", 64'(commit_value), 64'(exp_val[t]));
                    end else begin
                        check(exp_fault[t], "R9 fault on clean entry", 64'd0, 64'd1);
                        check(fault_pc == exp_pc[t], "R9 fault_pc", 64'(fault_pc), 64'(exp_pc[t]));
                        check(handler_pc == HPC, "R9 handler_pc", 64'(handler_pc), 64'(HPC));
                        sb_q.delete();
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!alloc_stall, "R1 alloc_stall", 64'(alloc_stall), 64'd0);
        check(alloc_tag == 0, "R1 alloc_tag", 64'(alloc_tag), 64'd0);
        check(!commit_valid && !fault_redirect, "R1 idle outputs", 64'({commit_valid, fault_redirect}), 64'd0);
        look(4'd5, BASE + 5, 1'b1, "R1 arf reset value");

        // Three entries, two naming register 1
        do_alloc(4'd1, 32'h1000);
        check(alloc_tag == 1, "R2 tag sequence", 64'(alloc_tag), 64'd1);
        do_alloc(4'd2, 32'h1004);
        do_alloc(4'd1, 32'h1008);
        check(alloc_tag == 3, "R2 tag sequence", 64'(alloc_tag), 64'd3);
        look(4'd1, '0, 1'b0, "R6 pending youngest");
        look(4'd7, BASE + 7, 1'b1, "R5 no match falls to arf");

        // Out-of-order writeback: youngest first
        do_wb(3'd2, 32'hCCC, 1'b0);
        check(!commit_valid, "R7 head not done", 64'(commit_valid), 64'd0);
        look(4'd1, 32'hCCC, 1'b1, "R4 youngest match");
        do_wb(3'd1, 32'hBBB, 1'b0);
        check(!commit_valid, "R7 head not done", 64'(commit_valid), 64'd0);
        look(4'd2, 32'hBBB, 1'b1, "R4 single match done");
        do_wb(3'd0, 32'hAAA, 1'b0);
        look(4'd1, 32'hCCC, 1'b1, "R4 youngest over older done");
        idle(5);
        look(4'd1, 32'hCCC, 1'b1, "R8 arf after drain");
        look(4'd2, 32'hBBB, 1'b1, "R8 arf after drain");

        // Fill the ring: tags 3..7 then wrap to 0..2
        for (int i = 0; i < DEPTH; i++) do_alloc(RW'(8 + i), 32'h3000 + 4 * i);
        check(alloc_stall, "R3 full stalls", 64'(alloc_stall), 64'd1);
        check(alloc_tag == 3, "R2 wrapped tail", 64'(alloc_tag), 64'd3);
        alloc_valid = 1'b1; alloc_dst = 4'd0; alloc_pc = 32'hDEAD;
        @(negedge clk);
        alloc_valid = 1'b0;
        check(alloc_stall && alloc_tag == 3, "R3 full alloc ignored", 64'(alloc_tag), 64'd3);
        do_wb(3'd3, 32'h500, 1'b0);
        // Head retires in this cycle while the ring is still full
        check(commit_valid && alloc_stall, "R3 retire while full", 64'({commit_valid, alloc_stall}), 64'd3);
        alloc_valid = 1'b1; alloc_dst = 4'd0; alloc_pc = 32'hBEEF;
        @(negedge clk);
        alloc_valid = 1'b0;
        check(!alloc_stall && alloc_tag == 3, "R3 same-cycle alloc refused", 64'(alloc_tag), 64'd3);
        look(4'd0, BASE, 1'b1, "R3 refused alloc left no entry");
        for (int i = 1; i < DEPTH; i++) do_wb(IDXW'(3 + i), 32'h500 + i, 1'b0);
        idle(DEPTH + 2);
        check(sb_q.size() == 0, "R7 all retired", 64'(sb_q.size()), 64'd0);
        look(4'd15, 32'h507, 1'b1, "R8 arf after wrap");

        // Fault at head with a younger finished entry behind it
        do_alloc(4'd3, 32'h2000);
        do_alloc(4'd4, 32'h2004);
        do_wb(3'd4, 32'h444, 1'b0);
        do_wb(3'd3, 32'h0, 1'b1);
        check(fault_redirect && alloc_stall, "R10 stall during fault", 64'({fault_redirect, alloc_stall}), 64'd3);
        alloc_valid = 1'b1; alloc_dst = 4'd6; alloc_pc = 32'h2008;
        wb_valid = 1'b1; wb_tag = 3'd4; wb_value = 32'h999; wb_fault = 1'b0;
        @(negedge clk);
        alloc_valid = 1'b0; wb_valid = 1'b0;
        check(alloc_tag == 0 && !alloc_stall, "R9 ring empty after flush", 64'(alloc_tag), 64'd0);
        check(!fault_redirect && !commit_valid, "R9 single fault cycle", 64'({fault_redirect, commit_valid}), 64'd0);
        look(4'd3, BASE + 3, 1'b1, "R9 no write from faulting entry");
        look(4'd4, BASE + 4, 1'b1, "R9 younger entry discarded");
        look(4'd6, BASE + 6, 1'b1, "R10 alloc in fault cycle discarded");

        // Normal operation resumes at tag 0
        do_alloc(4'd5, 32'h8000);
        look(4'd5, '0, 1'b0, "R6 pending after flush");
        do_wb(3'd0, 32'h555, 1'b0);
        idle(3);
        look(4'd5, 32'h555, 1'b1, "R8 retire after flush");
        check(sb_q.size() == 0, "R7 scoreboard drained", 64'(sb_q.size()), 64'd0);

        finish_sim();
    end
endmodule